// File: doc/BRIEF.md
# Multichannel PWM Generator with Shared Timebase

This block produces a set of pulse-width-modulated logic outputs, one per channel, from a single free-running timebase. An 8-bit prescaler divides the input clock into ticks. An 8-bit period counter steps once per tick, so each period lasts 256 ticks. Each channel compares the period counter against its own 8-bit duty setting. A single global enable starts and stops every channel together.

Software programs the block through a small word-addressed register bus. Each channel has a duty register. A control word holds the prescaler and the enable. A further word holds a one-bit interrupt-enable flag, which is only stored. Duty and prescaler updates are double-buffered: a new value waits for the next period boundary, so a running waveform never shows a truncated or stretched pulse.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads as zero and every output is low.
- R2: Channel n's duty register is the 32-bit word at byte offset 4*n. It holds 8 bits in data bits [7:0], and bits [31:8] read as zero.
- R3: The control word sits at offset 0x50. Prescaler bits [3:0] map to data bits [3:0], prescaler bits [7:4] map to data bits [14:11], and the global enable is data bit 9. All other bits read as zero.
- R4: The word at offset 0x54 stores a flag in bit 0, with the other bits reading zero. The flag has no effect on any output.
- R5: A read at an unmapped or non-word-aligned offset returns zero. A write there changes no register.
- R6: With prescale value P, one tick lasts P+1 clock cycles and a period lasts 256 ticks.
- R7: A duty value V drives the output high for the first V+1 ticks of each period and low for the rest. V=0 gives a one-tick pulse.
- R8: A duty value of 255 keeps the output high for the whole period, with no low cycle between periods.
- R9: While the enable is 0, every output is low and the counters are held at zero. The cycle after the enable is written to 1 starts a fresh period at count 0, using the duty and prescaler values present at that write.
- R10: A duty value written while the block runs takes effect at the next period boundary.
- R11: A prescaler value written while the block runs takes effect at the next period boundary.
- R12: All channels share one timebase, and each channel follows its own duty setting independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Read data follows bus_addr in the same cycle. A write lands on the rising edge where bus_wr is high. Outputs respond in the cycle that follows that edge, so an enable write shows its first high output immediately after the edge. A buffered duty or prescaler value first appears in the cycle after the boundary edge, that is, the edge ending the tick with count 255. The bench drives and samples on falling edges and starts counting on the falling edge just after each write. Each pulse width is therefore checked as an exact number of high samples within a window of known length, and each boundary as the sample index where the new shape begins.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    // Fixed datapath widths: an 8-bit prescaler and an 8-bit period counter.
    localparam int PSC_W  = 8;
    localparam int CNT_W  = 8;
    localparam int DUTY_W = CNT_W;
    localparam int DATA_W = 32;

    // Register offsets (bytes) and field positions inside the control word.
    localparam int CTRL_OFS   = 'h50;
    localparam int IRQEN_OFS  = 'h54;
    localparam int PSC_LO_LSB = 0;
    localparam int PSC_HI_LSB = 11;
    localparam int EN_BIT     = 9;
    localparam int IRQEN_BIT  = 0;
    localparam int NIB_W      = PSC_W / 2;

    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [PSC_W-1:0] psc_cnt;  // clocks elapsed in the current tick
        logic [PSC_W-1:0] psc_act;  // prescale value in force this period
        logic [CNT_W-1:0] cnt;      // period counter, one step per tick
    } tb_state_t;

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic [NUM_CH-1:0][DUTY_W-1:0] duty_q,
    output logic [NUM_CH-1:0][DUTY_W-1:0] duty_d,
    output logic [PSC_W-1:0]              psc_q,
    output logic [PSC_W-1:0]              psc_d,
    output logic                          en_q
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] CTRL_IDX  = IDX_W'(CTRL_OFS / 4);
    localparam logic [IDX_W-1:0] IRQEN_IDX = IDX_W'(IRQEN_OFS / 4);

    typedef struct packed {
        logic [NUM_CH-1:0][DUTY_W-1:0] duty;
        logic [PSC_W-1:0]              psc;
        logic                          en;
        logic                          irq_en;
    } regs_t;

    regs_t r_d, r_q;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_idx = bus_addr[ADDR_W-1:2];

    // Data bits that no register field stores.
    logic unused_wdata;
    assign unused_wdata = ^{bus_wdata[DATA_W-1:PSC_HI_LSB+NIB_W], bus_wdata[10], bus_wdata[8]};

    // Next-state: decode a write into one register.
    always_comb begin
        r_d = r_q;
        if (bus_wr && aligned) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (word_idx == IDX_W'(i)) begin
                    r_d.duty[i] = bus_wdata[DUTY_W-1:0];
                end
            end
            if (word_idx == CTRL_IDX) begin
                r_d.psc = {bus_wdata[PSC_HI_LSB +: NIB_W], bus_wdata[PSC_LO_LSB +: NIB_W]};
                r_d.en  = bus_wdata[EN_BIT];
            end
            if (word_idx == IRQEN_IDX) begin
                r_d.irq_en = bus_wdata[IRQEN_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Read mux: unmapped or misaligned offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (word_idx == IDX_W'(i)) begin
                    bus_rdata[DUTY_W-1:0] = r_q.duty[i];
                end
            end
            if (word_idx == CTRL_IDX) begin
                bus_rdata[PSC_LO_LSB +: NIB_W] = r_q.psc[NIB_W-1:0];
                bus_rdata[PSC_HI_LSB +: NIB_W] = r_q.psc[PSC_W-1:NIB_W];
                bus_rdata[EN_BIT]              = r_q.en;
            end
            if (word_idx == IRQEN_IDX) begin
                bus_rdata[IRQEN_BIT] = r_q.irq_en;
            end
        end
    end

    assign duty_q = r_q.duty;
    assign duty_d = r_d.duty;
    assign psc_q  = r_q.psc;
    assign psc_d  = r_d.psc;
    assign en_q   = r_q.en;

endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_q,
    input  logic [PSC_W-1:0] psc_q,
    input  logic [PSC_W-1:0] psc_d,
    output logic [CNT_W-1:0] cnt,
    output logic [PSC_W-1:0] psc_cnt,
    output logic [PSC_W-1:0] psc_act,
    output logic             tick,
    output logic             wrap
);

    tb_state_t s_d, s_q;

    assign tick = en_q && (s_q.psc_cnt == s_q.psc_act);
    assign wrap = tick && (s_q.cnt == CNT_LAST);

    always_comb begin
        s_d = s_q;
        if (!en_q) begin
            // Idle: counters parked, prescale follows the register so a
            // write that also sets enable is taken at once.
            s_d.psc_cnt = '0;
            s_d.cnt     = '0;
            s_d.psc_act = psc_d;
        end else if (tick) begin
            s_d.psc_cnt = '0;
            s_d.cnt     = s_q.cnt + 1'b1;
            if (wrap) begin
                s_d.psc_act = psc_q;
            end
        end else begin
            s_d.psc_cnt = s_q.psc_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt     = s_q.cnt;
    assign psc_cnt = s_q.psc_cnt;
    assign psc_act = s_q.psc_act;

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_q,
    input  logic              wrap,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DUTY_W-1:0] duty_q,
    input  logic [DUTY_W-1:0] duty_d,
    output logic [DUTY_W-1:0] duty_act,
    output logic              pwm
);

    logic [DUTY_W-1:0] act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (!en_q) begin
            act_d = duty_d;
        end else if (wrap) begin
            act_d = duty_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    // High while the period count has not passed the duty value.
    assign pwm      = en_q && (cnt <= act_q);
    assign duty_act = act_q;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 1,   // at most CTRL_OFS/4 channels
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0][DUTY_W-1:0] duty_q, duty_d, duty_act;
    logic [PSC_W-1:0]              psc_q, psc_d, psc_cnt, psc_act;
    logic [CNT_W-1:0]              cnt;
    logic                          en_q, tick, wrap;

    pwm_bank_regs #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .duty_q   (duty_q),
        .duty_d   (duty_d),
        .psc_q    (psc_q),
        .psc_d    (psc_d),
        .en_q     (en_q)
    );

    pwm_bank_timebase tb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_q   (en_q),
        .psc_q  (psc_q),
        .psc_d  (psc_d),
        .cnt    (cnt),
        .psc_cnt(psc_cnt),
        .psc_act(psc_act),
        .tick   (tick),
        .wrap   (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_bank_chan chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_q    (en_q),
            .wrap    (wrap),
            .cnt     (cnt),
            .duty_q  (duty_q[c]),
            .duty_d  (duty_d[c]),
            .duty_act(duty_act[c]),
            .pwm     (pwm_out[c])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          en_q,
    input logic                          tick,
    input logic                          wrap,
    input logic [CNT_W-1:0]              cnt,
    input logic [PSC_W-1:0]              psc_cnt,
    input logic [PSC_W-1:0]              psc_act,
    input logic [NUM_CH-1:0][DUTY_W-1:0] duty_act,
    input logic [NUM_CH-1:0]             pwm_out,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [31:0]                   bus_rdata
);

    localparam logic [31:0] CTRL_MASK = 32'h0000_7A0F;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (pwm_out == '0));                                        // R9
    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> (cnt == '0 && psc_cnt == '0));                            // R9
    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (psc_cnt <= psc_act));                                     // R6
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !tick) |=> $stable(cnt));                                  // R6
    AST_DUTY_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wrap) |=> $stable(duty_act));                             // R10
    AST_PSC_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wrap) |=> $stable(psc_act));                              // R11
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && duty_act[0] == '1) |-> pwm_out[0]);                        // R8
    AST_CTRL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(CTRL_OFS)) |-> ((bus_rdata & ~CTRL_MASK) == 32'h0)); // R3

endmodule

bind pwm_bank pwm_bank_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_q     (en_q),
    .tick     (tick),
    .wrap     (wrap),
    .cnt      (cnt),
    .psc_cnt  (psc_cnt),
    .psc_act  (psc_act),
    .duty_act (duty_act),
    .pwm_out  (pwm_out),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;

    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(8)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_out  (pwm_out)
    );

    // {prescale[31:24], duty[23:16], expected high samples[15:0]}
    localparam logic [31:0] VEC [8] = '{
        32'h0000_0001, 32'h007F_0080, 32'h00FF_0100, 32'h0103_0008,
        32'h030A_002C, 32'h02FE_02FD, 32'h1205_0072, 32'h8000_0081
    };

    function automatic logic [31:0] ctrl_word(input logic [7:0] p, input logic e);
        return {17'b0, p[7:4], 1'b0, e, 5'b0, p[3:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write lands on the next rising edge; returns on the following falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hi;
        int hi2;
        int hi3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs", 32'(pwm_out), 32'h0);
        rd_check("R1 duty0", 8'h00, 32'h0);
        rd_check("R1 duty2", 8'h08, 32'h0);
        rd_check("R1 ctrl", 8'h50, 32'h0);
        rd_check("R1 irqen", 8'h54, 32'h0);

        // R2: duty registers keep 8 bits
        wr(8'h04, 32'hFFFF_FFAB);
        wr(8'h08, 32'h1234_5678);
        rd_check("R2 duty1", 8'h04, 32'h0000_00AB);
        rd_check("R2 duty2", 8'h08, 32'h0000_0078);
        rd_check("R2 duty0 untouched", 8'h00, 32'h0);

        // R3: control fields
        wr(8'h50, 32'hFFFF_FFFF);
        rd_check("R3 ctrl all ones", 8'h50, 32'h0000_7A0F);
        wr(8'h50, ctrl_word(8'hA5, 1'b0));
        rd_check("R3 split prescale", 8'h50, 32'h0000_5005);
        wr(8'h50, 32'h0);

        // R4: flag storage
        wr(8'h54, 32'hFFFF_FFFF);
        rd_check("R4 irqen", 8'h54, 32'h1);
        rd_check("R4 ctrl unaffected", 8'h50, 32'h0);
        wr(8'h54, 32'h0);

        // R5: unmapped and misaligned
        wr(8'h4C, 32'hFF);
        rd_check("R5 unmapped 0x4C", 8'h4C, 32'h0);
        wr(8'h58, 32'hFF);
        rd_check("R5 unmapped 0x58", 8'h58, 32'h0);
        wr(8'h05, 32'h77);
        rd_check("R5 misaligned read", 8'h05, 32'h0);
        rd_check("R5 duty1 kept", 8'h04, 32'h0000_00AB);
        rd_check("R5 ctrl kept", 8'h50, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0);

        // R6/R7/R8: table of prescale and duty patterns on channel 0
        foreach (VEC[k]) begin
            logic [7:0] p;
            logic [7:0] v;
            int n;
            p = VEC[k][31:24];
            v = VEC[k][23:16];
            n = 256 * (int'(p) + 1);
            wr(8'h00, {24'h0, v});
            wr(8'h50, ctrl_word(p, 1'b0));
            wr(8'h50, ctrl_word(p, 1'b1));
            hi = 0;
            for (int s = 0; s < n; s++) begin
                if (pwm_out[0]) hi++;
                @(negedge clk);
            end
            check(v == 8'hFF ? "R8 full-period high" : "R7 high width", 32'(hi), 32'(VEC[k][15:0]));
            check("R6 next period starts high", 32'(pwm_out[0]), 32'h1);
            wr(8'h50, 32'h0);
        end

        // R12 with R4: three channels on one timebase, flag set
        wr(8'h00, 32'd5);
        wr(8'h04, 32'd100);
        wr(8'h08, 32'd255);
        wr(8'h54, 32'h1);
        wr(8'h50, ctrl_word(8'h00, 1'b1));
        hi = 0; hi2 = 0; hi3 = 0;
        for (int s = 0; s < 256; s++) begin
            if (pwm_out[0]) hi++;
            if (pwm_out[1]) hi2++;
            if (pwm_out[2]) hi3++;
            @(negedge clk);
        end
        check("R12 ch0", 32'(hi), 32'd6);
        check("R12 ch1", 32'(hi2), 32'd101);
        check("R12 ch2 (R4 flag no effect)", 32'(hi3), 32'd256);
        wr(8'h50, 32'h0);
        wr(8'h54, 32'h0);
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0);

        // R9: disable forces low; re-enable starts a fresh period
        wr(8'h00, 32'd255);
        wr(8'h50, ctrl_word(8'h00, 1'b1));
        check("R9 running high", 32'(pwm_out[0]), 32'h1);
        repeat (30) @(negedge clk);
        wr(8'h50, 32'h0);
        check("R9 disabled low", 32'(pwm_out), 32'h0);
        wr(8'h00, 32'd0);
        wr(8'h50, ctrl_word(8'h00, 1'b1));
        repeat (100) @(negedge clk);
        wr(8'h50, 32'h0);
        wr(8'h50, ctrl_word(8'h00, 1'b1));
        check("R9 fresh period first tick", 32'(pwm_out[0]), 32'h1);
        @(negedge clk);
        check("R9 fresh period second tick", 32'(pwm_out[0]), 32'h0);
        wr(8'h50, 32'h0);

        // R10: duty written mid-period waits for the boundary
        wr(8'h00, 32'd9);
        wr(8'h50, ctrl_word(8'h00, 1'b1));
        hi = 0; hi2 = 0;
        for (int s = 0; s < 512; s++) begin
            if (pwm_out[0]) begin
                if (s < 256) hi++;
                else hi2++;
            end
            if (s == 50) begin
                bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'd199;
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        check("R10 current period keeps old duty", 32'(hi), 32'd10);
        check("R10 next period uses new duty", 32'(hi2), 32'd200);
        wr(8'h50, 32'h0);

        // R11: prescale written mid-period waits for the boundary
        wr(8'h00, 32'd0);
        wr(8'h50, ctrl_word(8'h00, 1'b1));
        hi = 0; hi2 = 0; hi3 = 0;
        for (int s = 0; s < 770; s++) begin
            if (pwm_out[0]) begin
                if (s < 256) hi++;
                else if (s < 768) hi2++;
                else hi3++;
            end
            if (s == 50) begin
                bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = ctrl_word(8'h01, 1'b1);
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        check("R11 old prescale period", 32'(hi), 32'd1);
        check("R11 new prescale pulse", 32'(hi2), 32'd2);
        check("R11 new period length", 32'(hi3), 32'd2);
        wr(8'h50, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule